// File: doc/BRIEF.md
# Stack Machine Byte/Short Arithmetic Unit

This unit is the arithmetic and logic stage of a stack-machine core. It takes the two values at the top of a data stack, `opA` (the topmost) and `opB` (the one below it), together with an opcode and a width flag. It computes increment, add, subtract, multiply, divide, bitwise AND/OR/XOR, a combined two-way shift, or one of four unsigned comparisons. The surrounding core pops the operands and pushes the result. This unit only computes the result and reports how many bytes should be pushed.

Operands are presented for one cycle with `inValid` high. The result appears on the following cycle with `outValid` high, and it stays on `result` until the next accepted operation. In byte mode only the low byte of each operand takes part, and the result is one byte. In short mode the full 16 bits take part, and arithmetic and logic results are two bytes. Comparisons always give a one-byte 0/1 result.

Top module: `salu_top`

## Requirements
- R1: While `rstN` is low, `outValid`, `result` and `resultWide` are all 0.
- R2: An accepted operation (`inValid` high with a supported opcode) at clock edge N gives `outValid` high after edge N+1, for exactly that one cycle. Back-to-back operations each give their own result on successive cycles.
- R3: With `shortMode` low, only bits [7:0] of each operand are used. `result[15:8]` is 0 and `resultWide` is 0.
- R4: With `shortMode` high, all 16 operand bits are used. Arithmetic and logic results wrap modulo 2^16, and `resultWide` is 1.
- R5: Opcode 0x01 gives `opA`+1, wrapping at the active width.
- R6: Opcode 0x18 gives `opB`+`opA`, 0x19 gives `opB`-`opA`, and 0x1a gives `opB`*`opA`. All are unsigned and truncated to the active width.
- R7: Opcode 0x1b gives the unsigned quotient `opB`/`opA`. When the active-width `opA` is zero, the result is 0.
- R8: Opcodes 0x1c, 0x1d and 0x1e give the bitwise AND, OR and XOR of the operands.
- R9: Opcode 0x1f shifts `opB` using the control byte `opA[7:0]` in both modes. The value is first shifted right by `opA[3:0]`, then shifted left by `opA[7:4]`. The result is truncated to the active width.
- R10: Opcodes 0x08 (equal), 0x09 (not equal), 0x0a (`opB` > `opA`) and 0x0b (`opB` < `opA`) compare unsigned operands at the active width. Each gives `result` 1 or 0 with `resultWide` 0, in both modes.
- R11: An unsupported opcode does not raise `outValid` and leaves `result` and `resultWide` unchanged.
- R12: Without `inValid`, `outValid` is low on the next cycle and `result` and `resultWide` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| opcode | input | 8 | Operation code |
| shortMode | input | 1 | 1 = 16-bit operation, 0 = 8-bit |
| opA | input | 16 | Top-of-stack operand |
| opB | input | 16 | Next-on-stack operand |
| outValid | output | 1 | Result valid, one cycle after an accepted strobe |
| result | output | 16 | Registered result |
| resultWide | output | 1 | 1 = push two bytes, 0 = push one byte |

## Verification
The bench checks the following corner cases:
- Division by a value whose low byte is zero but whose high byte is not. A design that tests the full operand for zero in byte mode would return a real quotient instead of 0.
- Short-mode shifts with junk in `opA[15:8]`, and byte-mode left shifts that overflow. A design that read all of `opA` as the shift control, or shifted in the wrong order, or forgot to truncate, would give a different value.
- Short-mode comparisons. A design that pushes two bytes here, or compares only the low bytes, would report `resultWide` 1 or the wrong truth value.
- Unsupported opcodes. A design that still loads the result register on these would overwrite the held value.

// File: rtl/salu_pkg.sv
package salu_pkg;

  localparam logic [7:0] OPC_INC = 8'h01;
  localparam logic [7:0] OPC_EQ  = 8'h08;
  localparam logic [7:0] OPC_NE  = 8'h09;
  localparam logic [7:0] OPC_GT  = 8'h0a;
  localparam logic [7:0] OPC_LT  = 8'h0b;
  localparam logic [7:0] OPC_ADD = 8'h18;
  localparam logic [7:0] OPC_SUB = 8'h19;
  localparam logic [7:0] OPC_MUL = 8'h1a;
  localparam logic [7:0] OPC_DIV = 8'h1b;
  localparam logic [7:0] OPC_AND = 8'h1c;
  localparam logic [7:0] OPC_OR  = 8'h1d;
  localparam logic [7:0] OPC_XOR = 8'h1e;
  localparam logic [7:0] OPC_SFT = 8'h1f;

  typedef enum logic [3:0] {
    OP_NONE, OP_INC, OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_AND,
    OP_OR, OP_XOR, OP_SFT, OP_EQ, OP_NE, OP_GT, OP_LT
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    aluOp_e op;
    logic   wide;
  } aluCtl_t;

endpackage

// File: rtl/salu_ctrl.sv
module salu_ctrl
  import salu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] opcode,
  input  logic       shortMode,
  output aluCtl_t    ctl,
  output logic       outValid
);

  aluOp_e decOp;
  logic   isCmp;

  always_comb begin
    unique case (opcode)
      OPC_INC: decOp = OP_INC;
      OPC_ADD: decOp = OP_ADD;
      OPC_SUB: decOp = OP_SUB;
      OPC_MUL: decOp = OP_MUL;
      OPC_DIV: decOp = OP_DIV;
      OPC_AND: decOp = OP_AND;
      OPC_OR:  decOp = OP_OR;
      OPC_XOR: decOp = OP_XOR;
      OPC_SFT: decOp = OP_SFT;
      OPC_EQ:  decOp = OP_EQ;
      OPC_NE:  decOp = OP_NE;
      OPC_GT:  decOp = OP_GT;
      OPC_LT:  decOp = OP_LT;
      default: decOp = OP_NONE;
    endcase
  end

  assign isCmp    = (decOp == OP_EQ) || (decOp == OP_NE) ||
                    (decOp == OP_GT) || (decOp == OP_LT);
  assign ctl.op   = decOp;
  assign ctl.load = inValid && (decOp != OP_NONE);
  assign ctl.wide = shortMode && !isCmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= ctl.load;
  end

endmodule

// File: rtl/salu_dpath.sv
module salu_dpath
  import salu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtl_t           ctl,
  input  logic              shortMode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic              resultWide
);

  localparam int HALF_W = WORD_W / 2;
  localparam int NIB_W  = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] LOW_MASK = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};

  logic [WORD_W-1:0] aEff, bEff, raw, fitted;
  logic [HALF_W-1:0] shCtl;
  logic [NIB_W-1:0]  rAmt, lAmt;

  assign aEff  = shortMode ? opA : (opA & LOW_MASK);
  assign bEff  = shortMode ? opB : (opB & LOW_MASK);
  assign shCtl = opA[HALF_W-1:0];
  assign rAmt  = shCtl[NIB_W-1:0];
  assign lAmt  = shCtl[2*NIB_W-1:NIB_W];

  always_comb begin
    raw = '0;
    unique case (ctl.op)
      OP_INC:  raw = aEff + 1'b1;
      OP_ADD:  raw = bEff + aEff;
      OP_SUB:  raw = bEff - aEff;
      OP_MUL:  raw = bEff * aEff;
      OP_DIV:  raw = (aEff == '0) ? '0 : bEff / aEff;
      OP_AND:  raw = bEff & aEff;
      OP_OR:   raw = bEff | aEff;
      OP_XOR:  raw = bEff ^ aEff;
      OP_SFT:  raw = (bEff >> rAmt) << lAmt;
      OP_EQ:   raw = {{(WORD_W-1){1'b0}}, bEff == aEff};
      OP_NE:   raw = {{(WORD_W-1){1'b0}}, bEff != aEff};
      OP_GT:   raw = {{(WORD_W-1){1'b0}}, bEff >  aEff};
      OP_LT:   raw = {{(WORD_W-1){1'b0}}, bEff <  aEff};
      default: raw = '0;
    endcase
  end

  assign fitted = ctl.wide ? raw : (raw & LOW_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result     <= '0;
      resultWide <= 1'b0;
    end else if (ctl.load) begin
      result     <= fitted;
      resultWide <= ctl.wide;
    end
  end

endmodule

// File: rtl/salu_top.sv
module salu_top
  import salu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        opcode,
  input  logic              shortMode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result,
  output logic              resultWide
);

  aluCtl_t ctl;

  salu_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .shortMode(shortMode), .ctl(ctl), .outValid(outValid)
  );

  salu_dpath #(.WORD_W(WORD_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .shortMode(shortMode),
    .opA(opA), .opB(opB), .result(result), .resultWide(resultWide)
  );

endmodule

// File: rtl/salu_chk.sv
module salu_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [7:0]        opcode,
  input logic              shortMode,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              outValid,
  input logic [WORD_W-1:0] result,
  input logic              resultWide
);

  localparam int HALF_W = WORD_W / 2;

  logic known, isCmp, divZero;
  assign isCmp   = opcode inside {8'h08, 8'h09, 8'h0a, 8'h0b};
  assign known   = isCmp || opcode == 8'h01 ||
                   (opcode >= 8'h18 && opcode <= 8'h1f);
  assign divZero = (opcode == 8'h1b) &&
                   (shortMode ? (opA == '0) : (opA[HALF_W-1:0] == '0));

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0 && !resultWide));

  a_r2_valid_next: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && known) |=> outValid);

  a_r11_unknown_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !known) |=> (!outValid && $stable(result) && $stable(resultWide)));

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result) && $stable(resultWide)));

  a_r3_byte_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && known && !shortMode) |=> (!resultWide && result[WORD_W-1:HALF_W] == '0));

  a_r4_short_wide: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && known && !isCmp && shortMode) |=> resultWide);

  a_r10_cmp_bit: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isCmp) |=> (!resultWide && result <= 1));

  a_r7_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && divZero) |=> (result == '0));

endmodule

bind salu_top salu_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
  .shortMode(shortMode), .opA(opA), .opB(opB), .outValid(outValid),
  .result(result), .resultWide(resultWide)
);

// File: tb/salu_top_tb_top.sv
`timescale 1ns/1ps
module salu_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        shortMode = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic        outValid, resultWide;
  logic [15:0] result;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  salu_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .shortMode(shortMode), .opA(opA), .opB(opB), .outValid(outValid),
    .result(result), .resultWide(resultWide)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic [7:0]  op;
    logic        sh;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] expR;
    logic        expW;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{8'd5,  8'h01, 1'b0, 16'h12FF, 16'h0000, 16'h0000, 1'b0}, // R5 R3 byte wrap
    '{8'd5,  8'h01, 1'b1, 16'h12FF, 16'h0000, 16'h1300, 1'b1}, // R5 R4
    '{8'd6,  8'h18, 1'b0, 16'h0190, 16'h0280, 16'h0010, 1'b0}, // R6 R3
    '{8'd6,  8'h18, 1'b1, 16'h8001, 16'h8002, 16'h0003, 1'b1}, // R6 R4
    '{8'd6,  8'h19, 1'b0, 16'h0007, 16'h0005, 16'h00FE, 1'b0}, // R6 sub
    '{8'd6,  8'h19, 1'b1, 16'h0001, 16'h1000, 16'h0FFF, 1'b1}, // R6
    '{8'd6,  8'h1a, 1'b0, 16'h0011, 16'h0010, 16'h0010, 1'b0}, // R6 mul
    '{8'd6,  8'h1a, 1'b1, 16'h0100, 16'h0123, 16'h2300, 1'b1}, // R6 R4
    '{8'd7,  8'h1b, 1'b0, 16'h0007, 16'h0064, 16'h000E, 1'b0}, // R7
    '{8'd7,  8'h1b, 1'b1, 16'h0000, 16'h1234, 16'h0000, 1'b1}, // R7 zero
    '{8'd7,  8'h1b, 1'b0, 16'h0100, 16'h0050, 16'h0000, 1'b0}, // R7 low-byte zero
    '{8'd8,  8'h1c, 1'b1, 16'h3C3C, 16'hF0F0, 16'h3030, 1'b1}, // R8
    '{8'd8,  8'h1d, 1'b0, 16'hFF05, 16'h00A0, 16'h00A5, 1'b0}, // R8 R3
    '{8'd8,  8'h1e, 1'b1, 16'h0F0F, 16'hFFFF, 16'hF0F0, 1'b1}, // R8
    '{8'd9,  8'h1f, 1'b0, 16'h0012, 16'h00B4, 16'h005A, 1'b0}, // R9
    '{8'd9,  8'h1f, 1'b1, 16'h0084, 16'h1234, 16'h2300, 1'b1}, // R9
    '{8'd9,  8'h1f, 1'b1, 16'hFF21, 16'h00F0, 16'h01E0, 1'b1}, // R9 high a ignored
    '{8'd9,  8'h1f, 1'b0, 16'h0010, 16'h0081, 16'h0002, 1'b0}, // R9 overflow
    '{8'd10, 8'h08, 1'b1, 16'h1234, 16'h1234, 16'h0001, 1'b0}, // R10
    '{8'd10, 8'h08, 1'b1, 16'h1234, 16'h5534, 16'h0000, 1'b0}, // R10
    '{8'd10, 8'h08, 1'b0, 16'h1234, 16'h5534, 16'h0001, 1'b0}, // R10 R3
    '{8'd10, 8'h09, 1'b0, 16'h0007, 16'h0007, 16'h0000, 1'b0}, // R10
    '{8'd10, 8'h0a, 1'b1, 16'h00FF, 16'h0100, 16'h0001, 1'b0}, // R10
    '{8'd10, 8'h0a, 1'b0, 16'h00FF, 16'h0100, 16'h0000, 1'b0}, // R10
    '{8'd10, 8'h0b, 1'b0, 16'h0080, 16'h0001, 16'h0001, 1'b0}, // R10
    '{8'd10, 8'h0b, 1'b1, 16'h0001, 16'h8000, 16'h0000, 1'b0}  // R10
  };

  task automatic check(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {valid,wide,result}=%h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [7:0] op, logic sh, logic [15:0] a, logic [15:0] b);
    @(negedge clk);
    inValid = 1'b1; opcode = op; shortMode = sh; opA = a; opB = b;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1", {outValid, resultWide, result}, 18'h0);
    @(negedge clk) rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].sh, VEC[i].a, VEC[i].b);
      @(posedge clk); #1;
      check($sformatf("R%0d", VEC[i].req), {outValid, resultWide, result},
            {1'b1, VEC[i].expW, VEC[i].expR});
      idle();
    end

    // R11: unsupported opcode after a known result 0x0003 wide
    drive(8'h18, 1'b1, 16'h0001, 16'h0002);
    @(posedge clk); #1;
    check("R4", {outValid, resultWide, result}, {2'b11, 16'h0003});
    drive(8'h02, 1'b0, 16'h00FF, 16'h00FF);
    @(posedge clk); #1;
    check("R11", {outValid, resultWide, result}, {2'b01, 16'h0003});
    idle();
    // R12: idle cycles hold the result
    repeat (2) @(posedge clk);
    #1 check("R12", {outValid, resultWide, result}, {2'b01, 16'h0003});

    // R2: back-to-back strobes
    drive(8'h18, 1'b0, 16'h0001, 16'h0002);
    @(posedge clk); #1;
    check("R2", {outValid, resultWide, result}, {2'b10, 16'h0003});
    drive(8'h0b, 1'b1, 16'h0005, 16'h0004);
    @(posedge clk); #1;
    check("R2", {outValid, resultWide, result}, {2'b10, 16'h0001});
    idle();
    @(posedge clk); #1;
    check("R2", {outValid, resultWide, result}, {2'b00, 16'h0001});

    // R1: reset in the middle clears the outputs
    @(negedge clk) rstN = 1'b0;
    #1 check("R1", {outValid, resultWide, result}, 18'h0);
    @(negedge clk) rstN = 1'b1;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule